// File: doc/BRIEF.md
# Floating-Point Compare and Condition-Code Unit

This block compares two IEEE-754 operands and writes the outcome into a small bank of condition-code bits. An operand is a 32-bit single, a 64-bit double, or a pair of singles packed into one 64-bit word. A 4-bit selector chooses the outcome. Its three low bits pick which of the relations "less", "equal" and "unordered" make the condition true. Its top bit makes a comparison with a NaN raise invalid-operation even when both NaNs are quiet. An absolute-value mode compares magnitudes only.

A request is accepted on a clock edge where `req_valid` is high. The outcome appears in registers on that same edge. `done_q` pulses and `invalid_q` reports the invalid-operation cause for that compare. When the caller has enabled invalid-operation traps, an invalid compare raises `trap_q` and leaves the condition-code bank untouched. The trap therefore pre-empts the condition write. A paired compare writes two neighbouring condition bits and merges the two invalid results.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset `cc_bank_q` is all zeros and `done_q`, `invalid_q` and `trap_q` are low.
- R2: `fmt` encoding: 2'b00 single, taken from `op_a[31:0]`/`op_b[31:0]` with the upper 32 bits ignored; 2'b01 double, using all 64 bits; 2'b10 paired single; 2'b11 is handled as double.
- R3: The condition bit is (sel[2] AND less) OR (sel[1] AND equal) OR (sel[0] AND unordered). Less is false whenever the operands are equal.
- R4: If either operand is a NaN (all-ones exponent, non-zero fraction), the pair is unordered and both less and equal are false.
- R5: A NaN whose top fraction bit is 1 is signaling, and one with that bit 0 is quiet. `invalid_q` is set when the pair is unordered and either sel[3] is 1 or either operand is signaling. Ordered pairs never set it, whatever sel[3] is.
- R6: With `abs_en` high, both sign bits are cleared before the compare.
- R7: +0 and -0 are equal. Other non-NaN values, infinities included, are ordered by sign and magnitude, so a more negative value is less.
- R8: For paired single, the low halves are compared into bit `cc_idx` and the high halves into bit (`cc_idx`+1) mod NUM_CC. `invalid_q` is the OR of the two lanes.
- R9: If the compare is invalid and `trap_en` is high, `trap_q` is set and no condition bit changes. Otherwise `trap_q` stays low and the condition bit or bits are written.
- R10: Results appear on the edge that samples `req_valid` high, and `done_q` is high for exactly that cycle. Without a request, `cc_bank_q` holds and `done_q`, `invalid_q` and `trap_q` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Compare request this cycle |
| fmt | input | 2 | Operand format (R2) |
| sel | input | 4 | Condition selector (bit 3 forces signaling) |
| abs_en | input | 1 | Compare magnitudes only |
| cc_idx | input | 3 | Condition-code bit to write |
| trap_en | input | 1 | Invalid-operation trap enabled |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cc_bank_q | output | 8 | Condition-code bank |
| done_q | output | 1 | Compare completed pulse |
| invalid_q | output | 1 | Invalid-operation cause of the last compare |
| trap_q | output | 1 | Trap raised, condition write suppressed |

## Verification
The stimulus separates the three relations by applying less-than, equal and greater-than pairs under single-relation selectors. It then applies signed zeros, negative numbers and an infinity to show that ordering is sign-magnitude rather than plain integer order. Quiet and signaling NaNs are tried with sel[3] both clear and set, so the unordered path and the invalid flag are checked separately. Double operands whose low words are equal show that the format selects the full width. The reserved format code is used the same way. Paired operands written at the top index show the lane placement and the index wrap. A trapping NaN compare followed by a clean compare shows that the condition write is suppressed only on a trap.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_PAIRED = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int LANES     = DP_W / SP_W;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   val,
    input  logic                    abs_en,
    output logic                    is_nan,
    output logic                    is_snan,
    output logic                    is_zero,
    output logic                    sign,
    output logic [EXP_W+FRAC_W-1:0] mag
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f   = val[W-2 -: EXP_W];
        frac_f  = val[FRAC_W-1:0];
        is_nan  = (&exp_f) & (|frac_f);
        // legacy encoding: top fraction bit set marks a signaling NaN
        is_snan = is_nan & frac_f[FRAC_W-1];
        mag     = val[W-2:0];
        is_zero = ~|mag;
        sign    = val[W-1] & ~abs_en;
    end

endmodule

// File: rtl/fpcmp_core.sv
module fpcmp_core #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    input  logic [3:0]            sel,
    input  logic                  abs_en,
    output logic                  lt,
    output logic                  eq,
    output logic                  unord,
    output logic                  cond,
    output logic                  invalid
);
    localparam int MW = EXP_W + FRAC_W;

    logic          a_nan, a_snan, a_zero, a_sign;
    logic          b_nan, b_snan, b_zero, b_sign;
    logic [MW-1:0] a_mag, b_mag;
    logic          raw_lt;

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .val(a), .abs_en(abs_en), .is_nan(a_nan), .is_snan(a_snan),
        .is_zero(a_zero), .sign(a_sign), .mag(a_mag)
    );

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .val(b), .abs_en(abs_en), .is_nan(b_nan), .is_snan(b_snan),
        .is_zero(b_zero), .sign(b_sign), .mag(b_mag)
    );

    always_comb begin
        unord = a_nan | b_nan;
        eq    = ~unord & ((a_zero & b_zero) |
                          ((a_sign == b_sign) && (a_mag == b_mag)));
        unique case ({a_sign, b_sign})
            2'b10:   raw_lt = 1'b1;
            2'b01:   raw_lt = 1'b0;
            2'b00:   raw_lt = a_mag < b_mag;
            default: raw_lt = b_mag < a_mag;
        endcase
        lt      = ~unord & ~eq & raw_lt;
        cond    = (sel[2] & lt) | (sel[1] & eq) | (sel[0] & unord);
        invalid = unord & (sel[3] | a_snan | b_snan);
    end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int NUM_CC = 8,
    localparam int CC_IDX_W = $clog2(NUM_CC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          fmt,
    input  logic [3:0]          sel,
    input  logic                abs_en,
    input  logic [CC_IDX_W-1:0] cc_idx,
    input  logic                trap_en,
    input  logic [63:0]         op_a,
    input  logic [63:0]         op_b,
    output logic [NUM_CC-1:0]   cc_bank_q,
    output logic                done_q,
    output logic                invalid_q,
    output logic                trap_q
);
    typedef struct packed {
        logic [NUM_CC-1:0] cc_bank;
        logic              done;
        logic              invalid;
        logic              trap;
    } state_t;

    state_t st_d, st_q;

    // double-precision path
    logic dp_lt, dp_eq, dp_unord, dp_cond, dp_inv;

    fpcmp_core #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
        .a(op_a), .b(op_b), .sel(sel), .abs_en(abs_en),
        .lt(dp_lt), .eq(dp_eq), .unord(dp_unord),
        .cond(dp_cond), .invalid(dp_inv)
    );

    // single-precision lanes: lane 0 = low word, lane 1 = high word
    logic [LANES-1:0] sl_lt, sl_eq, sl_unord, sl_cond, sl_inv;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fpcmp_core #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
            .a(op_a[g*SP_W +: SP_W]), .b(op_b[g*SP_W +: SP_W]),
            .sel(sel), .abs_en(abs_en),
            .lt(sl_lt[g]), .eq(sl_eq[g]), .unord(sl_unord[g]),
            .cond(sl_cond[g]), .invalid(sl_inv[g])
        );

        p_lane_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sl_unord[g] |-> (!sl_lt[g] && !sl_eq[g]));
    end

    logic                c_lo, c_hi, pair, inv;
    logic [CC_IDX_W-1:0] hi_idx;

    always_comb begin
        hi_idx = cc_idx + CC_IDX_W'(1);
        c_hi   = 1'b0;
        pair   = 1'b0;
        unique case (fmt_e'(fmt))
            FMT_SINGLE: begin
                c_lo = sl_cond[0];
                inv  = sl_inv[0];
            end
            FMT_PAIRED: begin
                c_lo = sl_cond[0];
                c_hi = sl_cond[1];
                inv  = |sl_inv;
                pair = 1'b1;
            end
            default: begin
                c_lo = dp_cond;
                inv  = dp_inv;
            end
        endcase

        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.invalid = 1'b0;
        st_d.trap    = 1'b0;
        if (req_valid) begin
            st_d.done    = 1'b1;
            st_d.invalid = inv;
            // status is resolved first; a trap cancels the condition write
            if (inv && trap_en) begin
                st_d.trap = 1'b1;
            end else begin
                st_d.cc_bank[cc_idx] = c_lo;
                if (pair) st_d.cc_bank[hi_idx] = c_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_bank_q = st_q.cc_bank;
    assign done_q    = st_q.done;
    assign invalid_q = st_q.invalid;
    assign trap_q    = st_q.trap;

    p_dp_unord_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dp_unord |-> (!dp_lt && !dp_eq));

    p_force_signal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fmt == FMT_DOUBLE && dp_unord && sel[3]) |=> invalid_q);

    p_trap_keeps_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (cc_bank_q == $past(cc_bank_q)));

    p_trap_needs_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (invalid_q && done_q));

    p_done_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done_q);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (!invalid_q && !trap_q));

    p_idle_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(cc_bank_q));

endmodule

// File: tb/fpcmp_unit_test.sv
`timescale 1ns/1ps
module fpcmp_unit_test;

    localparam logic [31:0] ONE_S  = 32'h3F80_0000;
    localparam logic [31:0] TWO_S  = 32'h4000_0000;
    localparam logic [31:0] THR_S  = 32'h4040_0000;
    localparam logic [31:0] NTHR_S = 32'hC040_0000;
    localparam logic [31:0] NONE_S = 32'hBF80_0000;
    localparam logic [31:0] PINF_S = 32'h7F80_0000;
    localparam logic [31:0] QNAN_S = 32'h7FBF_FFFF;
    localparam logic [31:0] SNAN_S = 32'h7FC0_0000;
    localparam logic [31:0] NZ_S   = 32'h8000_0000;
    localparam logic [63:0] ONE_D  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO_D  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] QNAN_D = 64'h7FF7_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [3:0]  sel = 4'b0000;
    logic        abs_en = 1'b0;
    logic [2:0]  cc_idx = 3'd0;
    logic        trap_en = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [7:0]  cc_bank_q;
    logic        done_q, invalid_q, trap_q;

    int vectors = 0;
    int miss = 0;
    logic [7:0] exp_bank = '0;

    always #2 clk = ~clk;

    fpcmp_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fmt(fmt),
        .sel(sel), .abs_en(abs_en), .cc_idx(cc_idx), .trap_en(trap_en),
        .op_a(op_a), .op_b(op_b), .cc_bank_q(cc_bank_q), .done_q(done_q),
        .invalid_q(invalid_q), .trap_q(trap_q)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] f, input logic [3:0] s, input logic ab,
                         input logic [2:0] c, input logic te,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        req_valid = 1'b1; fmt = f; sel = s; abs_en = ab;
        cc_idx = c; trap_en = te; op_a = a; op_b = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic inv, input logic trp);
        check({tag, " bank"}, 64'(cc_bank_q), 64'(exp_bank));
        check({tag, " invalid"}, 64'(invalid_q), 64'(inv));
        check({tag, " trap"}, 64'(trap_q), 64'(trp));
        check({tag, " done"}, 64'(done_q), 64'd1);
    endtask

    task automatic t_reset;
        check("R1 bank", 64'(cc_bank_q), 64'd0);
        check("R1 done", 64'(done_q), 64'd0);
        check("R1 invalid", 64'(invalid_q), 64'd0);
        check("R1 trap", 64'(trap_q), 64'd0);
    endtask

    task automatic t_relations;
        // upper word is a signaling NaN, ignored for single format (R2)
        apply(2'b00, 4'b0100, 1'b0, 3'd0, 1'b0, {SNAN_S, ONE_S}, {SNAN_S, TWO_S});
        exp_bank[0] = 1'b1; expect_out("R2 R3 single lt", 1'b0, 1'b0);
        apply(2'b00, 4'b0100, 1'b0, 3'd1, 1'b0, {32'h0, TWO_S}, {32'h0, TWO_S});
        exp_bank[1] = 1'b0; expect_out("R3 lt on equal", 1'b0, 1'b0);
        apply(2'b00, 4'b0010, 1'b0, 3'd1, 1'b0, {32'h0, TWO_S}, {32'h0, TWO_S});
        exp_bank[1] = 1'b1; expect_out("R3 eq", 1'b0, 1'b0);
        apply(2'b00, 4'b0110, 1'b0, 3'd2, 1'b0, {32'h0, TWO_S}, {32'h0, ONE_S});
        exp_bank[2] = 1'b0; expect_out("R3 greater", 1'b0, 1'b0);
    endtask

    task automatic t_ordering;
        apply(2'b00, 4'b0010, 1'b0, 3'd3, 1'b0, {32'h0, NZ_S}, 64'h0);
        exp_bank[3] = 1'b1; expect_out("R7 -0 eq +0", 1'b0, 1'b0);
        apply(2'b00, 4'b0100, 1'b0, 3'd4, 1'b0, {32'h0, NZ_S}, 64'h0);
        exp_bank[4] = 1'b0; expect_out("R7 -0 not lt +0", 1'b0, 1'b0);
        apply(2'b00, 4'b0100, 1'b0, 3'd4, 1'b0, {32'h0, NTHR_S}, {32'h0, NONE_S});
        exp_bank[4] = 1'b1; expect_out("R7 -3 lt -1", 1'b0, 1'b0);
        apply(2'b00, 4'b0100, 1'b0, 3'd5, 1'b0, {32'h0, ONE_S}, {32'h0, PINF_S});
        exp_bank[5] = 1'b1; expect_out("R7 1 lt inf", 1'b0, 1'b0);
    endtask

    task automatic t_abs;
        apply(2'b00, 4'b0100, 1'b1, 3'd5, 1'b0, {32'h0, NTHR_S}, {32'h0, TWO_S});
        exp_bank[5] = 1'b0; expect_out("R6 abs -3 lt 2", 1'b0, 1'b0);
        apply(2'b00, 4'b0010, 1'b1, 3'd6, 1'b0, {32'h0, NONE_S}, {32'h0, ONE_S});
        exp_bank[6] = 1'b1; expect_out("R6 abs -1 eq 1", 1'b0, 1'b0);
    endtask

    task automatic t_nan;
        apply(2'b00, 4'b0001, 1'b0, 3'd0, 1'b0, {32'h0, QNAN_S}, {32'h0, ONE_S});
        exp_bank[0] = 1'b1; expect_out("R4 R5 qnan unordered quiet", 1'b0, 1'b0);
        apply(2'b00, 4'b0110, 1'b0, 3'd0, 1'b0, {32'h0, QNAN_S}, {32'h0, ONE_S});
        exp_bank[0] = 1'b0; expect_out("R4 nan not lt/eq", 1'b0, 1'b0);
        apply(2'b00, 4'b1001, 1'b0, 3'd0, 1'b0, {32'h0, ONE_S}, {32'h0, QNAN_S});
        exp_bank[0] = 1'b1; expect_out("R5 forced signaling", 1'b1, 1'b0);
        apply(2'b00, 4'b0001, 1'b0, 3'd6, 1'b0, {32'h0, SNAN_S}, {32'h0, ONE_S});
        exp_bank[6] = 1'b1; expect_out("R5 snan invalid", 1'b1, 1'b0);
        apply(2'b00, 4'b1100, 1'b0, 3'd2, 1'b0, {32'h0, ONE_S}, {32'h0, TWO_S});
        exp_bank[2] = 1'b1; expect_out("R5 ordered sel3 valid", 1'b0, 1'b0);
    endtask

    task automatic t_double;
        apply(2'b01, 4'b0100, 1'b0, 3'd2, 1'b0, ONE_D, TWO_D);
        exp_bank[2] = 1'b1; expect_out("R2 double lt", 1'b0, 1'b0);
        apply(2'b01, 4'b0001, 1'b0, 3'd1, 1'b0, QNAN_D, ONE_D);
        exp_bank[1] = 1'b1; expect_out("R4 double qnan", 1'b0, 1'b0);
        // low words equal: double view says not equal
        apply(2'b11, 4'b0010, 1'b0, 3'd3, 1'b0, ONE_D, TWO_D);
        exp_bank[3] = 1'b0; expect_out("R2 reserved as double", 1'b0, 1'b0);
    endtask

    task automatic t_paired;
        apply(2'b10, 4'b0100, 1'b0, 3'd7, 1'b0, {THR_S, ONE_S}, {ONE_S, TWO_S});
        exp_bank[7] = 1'b1; exp_bank[0] = 1'b0;
        expect_out("R8 paired wrap", 1'b0, 1'b0);
        apply(2'b10, 4'b0001, 1'b0, 3'd4, 1'b0, {SNAN_S, ONE_S}, {ONE_S, TWO_S});
        exp_bank[4] = 1'b0; exp_bank[5] = 1'b1;
        expect_out("R8 paired invalid OR", 1'b1, 1'b0);
    endtask

    task automatic t_trap;
        apply(2'b00, 4'b1001, 1'b0, 3'd3, 1'b1, {32'h0, QNAN_S}, {32'h0, ONE_S});
        expect_out("R9 trap holds bank", 1'b1, 1'b1);
        apply(2'b00, 4'b0100, 1'b0, 3'd3, 1'b1, {32'h0, ONE_S}, {32'h0, TWO_S});
        exp_bank[3] = 1'b1; expect_out("R9 no trap writes", 1'b0, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        fmt = 2'b00; sel = 4'b1111; cc_idx = 3'd3; trap_en = 1'b0;
        op_a = {32'h0, SNAN_S}; op_b = {32'h0, ONE_S};
        @(negedge clk);
        @(negedge clk);
        check("R10 idle bank", 64'(cc_bank_q), 64'(exp_bank));
        check("R10 idle done", 64'(done_q), 64'd0);
        check("R10 idle invalid", 64'(invalid_q), 64'd0);
        check("R10 idle trap", 64'(trap_q), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_relations();
        t_ordering();
        t_abs();
        t_nan();
        t_double();
        t_paired();
        t_trap();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

endmodule